// File: doc/BRIEF.md
# Domain-Owned Region Access Checker

This block sits in front of a shared memory or peripheral space and decides, for every incoming transaction, whether it may proceed. Each initiator's traffic carries a small domain tag. The checker holds a set of programmable regions, each an inclusive range of 4 KB pages. Every region has a read right and a write right for each domain, and one owning domain. An access is looked up by its tag, page and direction. The answer comes back one cycle later as either a grant or an error. The most recent denial is kept in a record of domain, address and direction.

Region policy is changed through a configuration port that also carries a domain tag. Only the region's owner may change the region. An owner can share its region by setting rights for other domains. Before the lock, an owner can also hand the region to another domain. A write from any other domain is dropped and raises a sticky violation flag. A one-cycle lock request makes the page ranges and owner fields fixed until reset. After the lock, owners can still adjust the rights of the regions they own.

Top module: `dom_region_guard`

## Requirements
- R1: After reset, every region is empty (base page all ones, limit page 0), owned by domain 0, and holds no rights. There is no response, `cfg_viol` and `err_vld` are 0, and every access is denied.
- R2: The page of an address is its bits above bit 11, which gives 4 KB granularity. A region matches when base page <= page <= limit page, both bounds included. The low 12 address bits never affect the decision.
- R3: The rights field of a region holds bit 2*d for domain d reading and bit 2*d+1 for domain d writing. A matching access is granted only when the bit for its domain and direction is set.
- R4: An access that matches no region is denied.
- R5: When several regions match, the one with the lowest index alone decides.
- R6: A configuration write whose domain is not the owner of the target region is dropped and sets `cfg_viol`. The flag stays set until reset.
- R7: Configuration ops are encoded as 0 = base (page from `cfg_data[31:12]`), 1 = limit (same bits), 2 = rights (`cfg_data[7:0]`) and 3 = owner (`cfg_data[1:0]`). A write accepted from the owner is applied to accesses from the next cycle on, so different domains can hold different rights to one region.
- R8: A one-cycle `lock_req` locks the block until reset. After the lock, base, limit and owner writes are dropped and set `cfg_viol`. Rights writes from the owner are still applied.
- R9: Before the lock, the owner may pass ownership to another domain. The new owner then gains configuration rights and the old owner loses them.
- R10: Each access cycle gives exactly one response one cycle later, with exactly one of `rsp_grant` and `rsp_err` set.
- R11: A denied access sets `err_vld` and stores its domain, full address and direction. A granted access leaves that record unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lock_req | input | 1 | One-cycle request to lock the layout and owners |
| cfg_valid | input | 1 | Configuration write strobe |
| cfg_dom | input | 2 | Domain tag of the configuration writer |
| cfg_region | input | 2 | Target region index |
| cfg_op | input | 2 | Field selector: 0 base, 1 limit, 2 rights, 3 owner |
| cfg_data | input | 32 | Write data |
| acc_valid | input | 1 | Access to check |
| acc_dom | input | 2 | Domain tag of the access |
| acc_addr | input | 32 | Access address |
| acc_write | input | 1 | 1 = write, 0 = read |
| rsp_valid | output | 1 | Response present |
| rsp_grant | output | 1 | Access allowed |
| rsp_err | output | 1 | Access denied (error response) |
| err_vld | output | 1 | A denial has been recorded since reset |
| err_dom | output | 2 | Domain of the last denied access |
| err_addr | output | 32 | Address of the last denied access |
| err_write | output | 1 | Direction of the last denied access |
| cfg_viol | output | 1 | Sticky flag for a rejected configuration write |

## Verification
Every domain and direction is swept across pages just inside and just outside each region, at both the first and the last byte of the page. This separates inclusive from exclusive bound handling and shows whether the low address bits leak into the decision. One page is covered by two regions that grant different rights, so the sweep shows which region wins. The full sweep is repeated after each policy phase: the initial setup, rejected writes from non-owners, a rights change by the owner, and writes made after the lock. Each repeat shows whether a dropped write left the policy untouched and whether an accepted write changed only the rights intended. The error record is compared after every single access.

// File: rtl/dorg_pkg.sv
package dorg_pkg;

   typedef enum logic [1:0] {
      CFG_BASE  = 2'd0,
      CFG_LIMIT = 2'd1,
      CFG_PERM  = 2'd2,
      CFG_OWNER = 2'd3
   } cfg_op_e;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/dorg_region_slot.sv
module dorg_region_slot
   import dorg_pkg::*;
#(
   parameter int NUM_DOMAINS = 4,
   parameter int PAGE_W      = 20,
   parameter int DOM_W       = $clog2(NUM_DOMAINS),
   parameter int PERM_W      = 2 * NUM_DOMAINS,
   parameter int RESET_OWNER = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lock_i,
   input  logic              wr_en,
   input  cfg_op_e           wr_op,
   input  logic [PAGE_W-1:0] wr_page,
   input  logic [PERM_W-1:0] wr_perm,
   input  logic [DOM_W-1:0]  wr_owner,
   input  logic [PAGE_W-1:0] acc_page,
   output logic              hit_o,
   output logic [PERM_W-1:0] perm_o,
   output logic [DOM_W-1:0]  owner_o
);

   logic [PAGE_W-1:0] base_q;
   logic [PAGE_W-1:0] limit_q;
   logic [PERM_W-1:0] perm_q;
   logic [DOM_W-1:0]  owner_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q  <= '1;
         limit_q <= '0;
         perm_q  <= '0;
         owner_q <= DOM_W'(RESET_OWNER);
      end else if (wr_en) begin
         case (wr_op)
            CFG_BASE:  base_q  <= wr_page;
            CFG_LIMIT: limit_q <= wr_page;
            CFG_PERM:  perm_q  <= wr_perm;
            CFG_OWNER: owner_q <= wr_owner;
            default:   ;
         endcase
      end
   end

   assign hit_o   = (acc_page >= base_q) && (acc_page <= limit_q);
   assign perm_o  = perm_q;
   assign owner_o = owner_q;

   AST_RANGE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      lock_i |=> ($stable(base_q) && $stable(limit_q))); // R8
   AST_OWNER_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      lock_i |=> $stable(owner_q)); // R9
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(perm_q) && $stable(owner_q))); // R6

endmodule

// File: rtl/dorg_cfg_gate.sv
module dorg_cfg_gate
   import dorg_pkg::*;
#(
   parameter int NUM_REGIONS = 4,
   parameter int DOM_W       = 2,
   parameter int REG_W       = $clog2(NUM_REGIONS)
) (
   input  logic                                cfg_valid,
   input  logic [DOM_W-1:0]                    cfg_dom,
   input  logic [REG_W-1:0]                    cfg_region,
   input  cfg_op_e                             cfg_op,
   input  logic                                locked,
   input  logic [NUM_REGIONS-1:0][DOM_W-1:0]   owners,
   output logic [NUM_REGIONS-1:0]              wr_en,
   output logic                                reject
);

   logic region_ok;
   logic owner_ok;
   logic op_ok;
   logic accept;
   logic [DOM_W-1:0] tgt_owner;

   always_comb begin
      tgt_owner = '0;
      for (int i = 0; i < NUM_REGIONS; i++)
         if (cfg_region == REG_W'(i)) tgt_owner = owners[i];
   end

   assign region_ok = ({1'b0, cfg_region} < (REG_W + 1)'(NUM_REGIONS));
   assign owner_ok  = (cfg_dom == tgt_owner);
   assign op_ok     = !locked || (cfg_op == CFG_PERM);
   assign accept    = cfg_valid && region_ok && owner_ok && op_ok;
   assign reject    = cfg_valid && !accept;

   for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_sel
      assign wr_en[g] = accept && (cfg_region == REG_W'(g));
   end

   always_comb begin
      AST_ONE_TARGET: assert ($onehot0(wr_en)); // R7
   end

endmodule

// File: rtl/dorg_first_hit.sv
module dorg_first_hit #(
   parameter int N     = 4,
   parameter int IDX_W = $clog2(N)
) (
   input  logic [N-1:0]     hit_i,
   output logic             any_o,
   output logic [IDX_W-1:0] idx_o
);

   always_comb begin
      any_o = 1'b0;
      idx_o = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (hit_i[i]) begin
            any_o = 1'b1;
            idx_o = IDX_W'(i);
         end
      end
   end

   always_comb begin
      if (any_o) begin
         AST_PICK_IS_HIT: assert (hit_i[idx_o]); // R5
         AST_PICK_LOWEST: assert ((hit_i & ((N'(1) << idx_o) - N'(1))) == '0); // R5
      end else begin
         AST_NONE_MEANS_EMPTY: assert (hit_i == '0); // R4
      end
   end

endmodule

// File: rtl/dom_region_guard.sv
module dom_region_guard
   import dorg_pkg::*;
#(
   parameter int NUM_DOMAINS = 4,
   parameter int NUM_REGIONS = 4,
   parameter int ADDR_W      = 32,
   parameter int PAGE_SHIFT  = 12,
   parameter int RESET_OWNER = 0,
   localparam int DOM_W      = $clog2(NUM_DOMAINS),
   localparam int REG_W      = $clog2(NUM_REGIONS),
   localparam int PAGE_W     = ADDR_W - PAGE_SHIFT,
   localparam int PERM_W     = 2 * NUM_DOMAINS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lock_req,
   input  logic              cfg_valid,
   input  logic [DOM_W-1:0]  cfg_dom,
   input  logic [REG_W-1:0]  cfg_region,
   input  logic [1:0]        cfg_op,
   input  logic [ADDR_W-1:0] cfg_data,
   input  logic              acc_valid,
   input  logic [DOM_W-1:0]  acc_dom,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              acc_write,
   output logic              rsp_valid,
   output logic              rsp_grant,
   output logic              rsp_err,
   output logic              err_vld,
   output logic [DOM_W-1:0]  err_dom,
   output logic [ADDR_W-1:0] err_addr,
   output logic              err_write,
   output logic              cfg_viol
);

   if (!is_pow2(NUM_DOMAINS) || NUM_DOMAINS < 2) begin : g_bad_dom
      $error("NUM_DOMAINS must be a power of two, at least 2");
   end
   if (NUM_REGIONS < 2) begin : g_bad_reg
      $error("NUM_REGIONS must be at least 2");
   end
   if (PAGE_SHIFT < 1 || PAGE_SHIFT >= ADDR_W) begin : g_bad_page
      $error("PAGE_SHIFT must lie inside the address");
   end
   if (PERM_W > ADDR_W || RESET_OWNER >= NUM_DOMAINS) begin : g_bad_fit
      $error("rights field or reset owner does not fit");
   end

   logic                              lock_q;
   cfg_op_e                           op_e;
   logic [NUM_REGIONS-1:0]            wr_en;
   logic                              cfg_reject;
   logic [NUM_REGIONS-1:0][DOM_W-1:0] owners;
   logic [PERM_W-1:0]                 perms [NUM_REGIONS];
   logic [NUM_REGIONS-1:0]            hits;
   logic                              any_hit;
   logic [REG_W-1:0]                  hit_idx;
   logic [PERM_W-1:0]                 sel_perm;
   logic                              allowed;
   logic [PAGE_W-1:0]                 acc_page;
   logic                              unused_cfg;

   assign op_e       = cfg_op_e'(cfg_op);
   assign acc_page   = acc_addr[ADDR_W-1:PAGE_SHIFT];
   assign unused_cfg = ^cfg_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lock_q <= 1'b0;
      else if (lock_req) lock_q <= 1'b1;
   end

   dorg_cfg_gate #(
      .NUM_REGIONS (NUM_REGIONS),
      .DOM_W       (DOM_W),
      .REG_W       (REG_W)
   ) u_gate (
      .cfg_valid  (cfg_valid),
      .cfg_dom    (cfg_dom),
      .cfg_region (cfg_region),
      .cfg_op     (op_e),
      .locked     (lock_q),
      .owners     (owners),
      .wr_en      (wr_en),
      .reject     (cfg_reject)
   );

   for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_slot
      dorg_region_slot #(
         .NUM_DOMAINS (NUM_DOMAINS),
         .PAGE_W      (PAGE_W),
         .DOM_W       (DOM_W),
         .PERM_W      (PERM_W),
         .RESET_OWNER (RESET_OWNER)
      ) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .lock_i   (lock_q),
         .wr_en    (wr_en[g]),
         .wr_op    (op_e),
         .wr_page  (cfg_data[ADDR_W-1:PAGE_SHIFT]),
         .wr_perm  (cfg_data[PERM_W-1:0]),
         .wr_owner (cfg_data[DOM_W-1:0]),
         .acc_page (acc_page),
         .hit_o    (hits[g]),
         .perm_o   (perms[g]),
         .owner_o  (owners[g])
      );
   end

   dorg_first_hit #(
      .N     (NUM_REGIONS),
      .IDX_W (REG_W)
   ) u_pick (
      .hit_i (hits),
      .any_o (any_hit),
      .idx_o (hit_idx)
   );

   assign sel_perm = perms[hit_idx];
   assign allowed  = any_hit && sel_perm[{acc_dom, acc_write}];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_grant <= 1'b0;
         rsp_err   <= 1'b0;
      end else begin
         rsp_valid <= acc_valid;
         rsp_grant <= acc_valid && allowed;
         rsp_err   <= acc_valid && !allowed;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_vld   <= 1'b0;
         err_dom   <= '0;
         err_addr  <= '0;
         err_write <= 1'b0;
      end else if (acc_valid && !allowed) begin
         err_vld   <= 1'b1;
         err_dom   <= acc_dom;
         err_addr  <= acc_addr;
         err_write <= acc_write;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_viol <= 1'b0;
      else if (cfg_reject) cfg_viol <= 1'b1;
   end

   AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |=> rsp_valid); // R10
   AST_RSP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $onehot({rsp_grant, rsp_err})); // R10
   AST_RSP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> !(rsp_grant || rsp_err)); // R10
   AST_NOMATCH_DENY: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !any_hit) |=> rsp_err); // R4
   AST_ERR_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !allowed) |=> (err_vld && err_dom == $past(acc_dom)
                                   && err_write == $past(acc_write))); // R11
   AST_NONOWNER_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_valid && cfg_dom != owners[cfg_region]) |=> cfg_viol); // R6
   AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_viol |=> cfg_viol); // R6
   AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |=> lock_q); // R8

endmodule

// File: tb/tb_dom_region_guard.sv
module tb_dom_region_guard;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lock_req = 1'b0;
   logic        cfg_valid = 1'b0;
   logic [1:0]  cfg_dom = '0;
   logic [1:0]  cfg_region = '0;
   logic [1:0]  cfg_op = '0;
   logic [31:0] cfg_data = '0;
   logic        acc_valid = 1'b0;
   logic [1:0]  acc_dom = '0;
   logic [31:0] acc_addr = '0;
   logic        acc_write = 1'b0;
   logic        rsp_valid, rsp_grant, rsp_err;
   logic        err_vld, err_write, cfg_viol;
   logic [1:0]  err_dom;
   logic [31:0] err_addr;

   always #5 clk = ~clk;

   dom_region_guard dut (
      .clk(clk), .rst_n(rst_n), .lock_req(lock_req),
      .cfg_valid(cfg_valid), .cfg_dom(cfg_dom), .cfg_region(cfg_region),
      .cfg_op(cfg_op), .cfg_data(cfg_data),
      .acc_valid(acc_valid), .acc_dom(acc_dom), .acc_addr(acc_addr),
      .acc_write(acc_write),
      .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_err(rsp_err),
      .err_vld(err_vld), .err_dom(err_dom), .err_addr(err_addr),
      .err_write(err_write), .cfg_viol(cfg_viol)
   );

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   int       m_base  [4];
   int       m_limit [4];
   int       m_owner [4];
   bit [7:0] m_perm  [4];
   bit       m_lock;
   bit       m_viol;
   bit       e_vld;
   int       e_dom;
   bit [31:0] e_addr;
   bit       e_wr;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int r = 0; r < 4; r++) begin
         m_base[r] = 32'h000F_FFFF; m_limit[r] = 0; m_owner[r] = 0; m_perm[r] = '0;
      end
      m_lock = 0; m_viol = 0; e_vld = 0; e_dom = 0; e_addr = '0; e_wr = 0;
   endtask

   function automatic int first_region(input bit [31:0] a);
      int pg = int'(a >> 12);
      for (int r = 0; r < 4; r++)
         if (pg >= m_base[r] && pg <= m_limit[r]) return r;
      return -1;
   endfunction

   task automatic cfg_write(input int d, input int r, input int op, input bit [31:0] data);
      bit ok;
      @(negedge clk);
      cfg_valid = 1; cfg_dom = 2'(d); cfg_region = 2'(r); cfg_op = 2'(op); cfg_data = data;
      @(negedge clk);
      cfg_valid = 0;
      ok = (d == m_owner[r]) && (!m_lock || op == 2);
      if (!ok) m_viol = 1;
      else case (op)
         0: m_base[r]  = int'(data >> 12);
         1: m_limit[r] = int'(data >> 12);
         2: m_perm[r]  = data[7:0];
         default: m_owner[r] = int'(data[1:0]);
      endcase
   endtask

   task automatic access(input int d, input bit [31:0] a, input bit w, input string req);
      int  r;
      bit  exp_g;
      @(negedge clk);
      acc_valid = 1; acc_dom = 2'(d); acc_addr = a; acc_write = w;
      @(negedge clk);
      acc_valid = 0;
      r = first_region(a);
      exp_g = (r >= 0) ? m_perm[r][2*d + int'(w)] : 1'b0;
      check(rsp_valid && (rsp_grant ^ rsp_err), "R10", "one response",
            {rsp_valid, rsp_grant, rsp_err}, {1'b1, exp_g, !exp_g});
      check(rsp_grant == exp_g, req, $sformatf("grant d%0d a%0h w%0d", d, a, w),
            rsp_grant, exp_g);
      if (!exp_g) begin
         e_vld = 1; e_dom = d; e_addr = a; e_wr = w;
      end
      check(err_vld == e_vld && int'(err_dom) == e_dom && err_addr == e_addr
            && err_write == e_wr, "R11", "error record",
            {err_vld, err_dom, err_addr, err_write},
            {e_vld, 2'(e_dom), e_addr, e_wr});
   endtask

   task automatic sweep();
      int pages [10] = '{0, 1, 2, 3, 4, 5, 6, 15, 16, 17};
      for (int p = 0; p < 10; p++)
         for (int off = 0; off < 2; off++)
            for (int d = 0; d < 4; d++)
               for (int w = 0; w < 2; w++) begin
                  bit [31:0] a = (32'(pages[p]) << 12) | (off == 1 ? 32'hFFF : 32'h0);
                  int r = first_region(a);
                  string lbl = (r < 0) ? "R4" : (pages[p] == 3) ? "R5" :
                               (off == 1) ? "R2" : "R3";
                  access(d, a, w[0], lbl);
               end
   endtask

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      check(!rsp_valid && !cfg_viol && !err_vld, "R1", "reset outputs",
            {rsp_valid, cfg_viol, err_vld}, 0);
      rst_n = 1;
      @(negedge clk);
      access(0, 32'h0, 1'b0, "R1");
      access(3, 32'hFFFF_F000, 1'b1, "R1");

      cfg_write(0, 0, 0, 32'h0000_1000);
      cfg_write(0, 0, 1, 32'h0000_3000);
      cfg_write(0, 0, 2, 32'h87);
      cfg_write(0, 1, 0, 32'h0000_3000);
      cfg_write(0, 1, 1, 32'h0000_5ABC);
      cfg_write(0, 1, 2, 32'hFF);
      cfg_write(0, 2, 3, 32'h2);
      cfg_write(2, 2, 0, 32'h0001_0000);
      cfg_write(2, 2, 1, 32'h0001_0FFF);
      cfg_write(2, 2, 2, 32'h30);
      check(cfg_viol == 0, "R6", "no violation after owner writes", cfg_viol, 0);
      access(2, 32'h0001_0004, 1'b1, "R9");
      sweep();

      cfg_write(0, 2, 2, 32'hFF);
      check(cfg_viol == 1, "R9", "old owner rejected", cfg_viol, 1);
      access(0, 32'h0001_0000, 1'b0, "R9");
      cfg_write(1, 0, 2, 32'hFF);
      access(1, 32'h0000_1000, 1'b1, "R6");
      check(cfg_viol == 1, "R6", "violation sticky", cfg_viol, 1);
      sweep();

      cfg_write(0, 0, 2, 32'h8F);
      access(1, 32'h0000_2000, 1'b1, "R7");
      sweep();

      @(negedge clk); lock_req = 1;
      @(negedge clk); lock_req = 0;
      m_lock = 1;
      cfg_write(0, 0, 0, 32'h0);
      access(0, 32'h0000_0000, 1'b0, "R8");
      cfg_write(2, 2, 3, 32'h1);
      cfg_write(2, 2, 2, 32'hC0);
      access(3, 32'h0001_0000, 1'b0, "R8");
      access(2, 32'h0001_0000, 1'b1, "R8");
      cfg_write(1, 2, 2, 32'hFF);
      access(1, 32'h0001_0000, 1'b0, "R9");
      sweep();

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule